// File: doc/BRIEF.md
# Sampling converter serial port model

This block is a synthesizable stand-in for the digital side of a 16-bit successive-approximation converter's three-wire serial port. A host controller under test drives an active-low chip select and a data clock. The block answers on a data line with a separate output-enable, which stands in for a tri-state pad. Both host inputs are asynchronous to the system clock. Each one passes through a multi-flop synchronizer, and its edges are detected in the system clock domain.

A falling chip select starts a frame and captures the parallel sample word at once. The data line stays released during an acquisition window of four falling data-clock edges. On the fifth fall it drives a low lead-in bit. It then shifts the captured word out most significant bit first, and then replays it least significant bit first. B0 is not sent twice. After the replayed B15 the line is released and the frame is over until chip select is cycled. The block also reports its power state, the bit index now on the line and a frame-finished flag.

Top module: `sar_port_emu`

## Requirements
- R1: While the synchronized chip select is high, `dout_oe_o` is 0 and `pwr_state_o` is 2'b10 (full power-down), whatever the data clock does.
- R2: A falling chip select captures `sample_i` in that same cycle. Changes to `sample_i` later in the frame do not alter the bits sent. Right after the fall, `dout_oe_o` is 0 and `pwr_state_o` is 2'b00.
- R3: After falling data-clock edges 1 to 4 of a frame, `dout_oe_o` stays 0. The 5th fall sets `dout_oe_o` to 1 with `dout_o` = 0.
- R4: Falls 6 to 21 put bits B15 down to B0 on `dout_o`, and `bit_pos_o` shows the index of the bit on the line.
- R5: Falls 22 to 36 put bits B1 up to B15 on `dout_o`, so B0 is not repeated, and `bit_pos_o` follows the index.
- R6: The 37th fall releases the line (`dout_oe_o` = 0) and sets `cycle_done_o`. Later data-clock falls change nothing until chip select goes high and then low again, which starts a normal frame.
- R7: `pwr_state_o` reads 2'b00 (active) from the chip select fall through B0 of the forward word. It reads 2'b01 (analog section off) from the first replayed bit onward while chip select stays low.
- R8: Raising chip select at any point in a frame ends it: `dout_oe_o` = 0, `cycle_done_o` = 0, `bit_pos_o` = 0, `pwr_state_o` = 2'b10.
- R9: Rising data-clock edges never change `dout_o`, `dout_oe_o` or `bit_pos_o`.
- R10: After synchronous reset, `dout_oe_o` = 0, `cycle_done_o` = 0, `bit_pos_o` = 0 and `pwr_state_o` = 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the host lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Asynchronous chip select, low starts a frame |
| dclk_i | input | 1 | Asynchronous data clock from the host |
| sample_i | input | DATA_W | Parallel conversion result to be sent |
| dout_o | output | 1 | Serial data bit |
| dout_oe_o | output | 1 | Drive enable for the data line, 0 means released |
| pwr_state_o | output | 2 | 00 active, 01 analog off, 10 full power-down |
| bit_pos_o | output | $clog2(DATA_W) | Index of the word bit now on the line |
| cycle_done_o | output | 1 | Frame finished, waiting for chip select to cycle |

## Verification
The bench goes after the seam between the forward and replayed words. A design that repeats B0 or skips B1 there would push every later bit off by one place. It checks that falls after the replayed B15 are ignored. A design that wraps around would start driving the line again. It raises chip select during acquisition and in the middle of the forward word, where a sequencer that waits for the word to finish would keep driving. It also changes the parallel input after the frame starts, which exposes a design that samples late rather than at the chip select fall.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

  // Frame phases of the serial sequencer
  typedef enum logic [2:0] {
    PH_OFF  = 3'd0,  // chip select high, nothing driven
    PH_ACQ  = 3'd1,  // acquisition window, line released
    PH_NULL = 3'd2,  // low lead-in bit on the line
    PH_FWD  = 3'd3,  // word going out, high bit first
    PH_REV  = 3'd4,  // word replayed, low bit first
    PH_DONE = 3'd5   // frame over, clocks ignored
  } phase_e;

  // Power report encoding
  typedef enum logic [1:0] {
    PWR_ACTIVE     = 2'b00,
    PWR_ANALOG_OFF = 2'b01,
    PWR_FULL_OFF   = 2'b10
  } pwr_e;

endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic lvl_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= chain[STAGES-1];
  end

  assign lvl_o  = chain[STAGES-1];
  assign fall_o = prev & ~chain[STAGES-1];

endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq
  import sar_port_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ACQ_FALLS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cs_lvl,
  input  logic                      cs_fall,
  input  logic                      dclk_fall,
  input  logic [DATA_W-1:0]         sample_i,
  output phase_e                    phase_o,
  output logic [$clog2(DATA_W)-1:0] idx_o,
  output logic                      dout_o,
  output logic                      oe_o
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam int ACQ_W = $clog2(ACQ_FALLS + 1);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DATA_W - 1);
  localparam logic [ACQ_W-1:0] ACQ_END = ACQ_W'(ACQ_FALLS);

  phase_e             phase;
  logic [ACQ_W-1:0]   acq_cnt;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  word;
  logic               dout_q;
  logic               oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_OFF;
      acq_cnt <= '0;
      idx     <= '0;
      word    <= '0;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (cs_fall) begin
      // new frame: capture the word now, no pipeline delay
      phase   <= PH_ACQ;
      acq_cnt <= '0;
      idx     <= '0;
      word    <= sample_i;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (cs_lvl) begin
      // chip select high aborts or holds off any frame
      phase   <= PH_OFF;
      idx     <= '0;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (dclk_fall) begin
      unique case (phase)
        PH_ACQ: begin
          if (acq_cnt == ACQ_END) begin
            phase  <= PH_NULL;
            oe_q   <= 1'b1;
            dout_q <= 1'b0;
          end else begin
            acq_cnt <= acq_cnt + 1'b1;
          end
        end
        PH_NULL: begin
          phase  <= PH_FWD;
          idx    <= IDX_TOP;
          dout_q <= word[DATA_W-1];
        end
        PH_FWD: begin
          if (idx == '0) begin
            // turn around without sending the low bit twice
            phase  <= PH_REV;
            idx    <= IDX_W'(1);
            dout_q <= word[1];
          end else begin
            idx    <= idx - 1'b1;
            dout_q <= word[idx - 1'b1];
          end
        end
        PH_REV: begin
          if (idx == IDX_TOP) begin
            phase  <= PH_DONE;
            idx    <= '0;
            oe_q   <= 1'b0;
            dout_q <= 1'b0;
          end else begin
            idx    <= idx + 1'b1;
            dout_q <= word[idx + 1'b1];
          end
        end
        default: ;  // PH_OFF and PH_DONE hold
      endcase
    end
  end

  assign phase_o = phase;
  assign idx_o   = idx;
  assign dout_o  = dout_q;
  assign oe_o    = oe_q;

endmodule

// File: rtl/sar_status.sv
module sar_status
  import sar_port_pkg::*;
(
  input  phase_e     phase_i,
  output logic [1:0] pwr_o,
  output logic       done_o
);

  always_comb begin
    unique case (phase_i)
      PH_OFF:           pwr_o = PWR_FULL_OFF;
      PH_REV, PH_DONE:  pwr_o = PWR_ANALOG_OFF;
      default:          pwr_o = PWR_ACTIVE;
    endcase
    done_o = (phase_i == PH_DONE);
  end

endmodule

// File: rtl/sar_port_emu.sv
module sar_port_emu
  import sar_port_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ACQ_FALLS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cs_n_i,
  input  logic                      dclk_i,
  input  logic [DATA_W-1:0]         sample_i,
  output logic                      dout_o,
  output logic                      dout_oe_o,
  output logic [1:0]                pwr_state_o,
  output logic [$clog2(DATA_W)-1:0] bit_pos_o,
  output logic                      cycle_done_o
);

  logic   cs_lvl;
  logic   cs_fall;
  logic   dclk_lvl;
  logic   dclk_fall;
  phase_e phase;
  logic [$clog2(DATA_W)-1:0] idx;

  sar_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i(cs_n_i),
    .lvl_o  (cs_lvl),
    .fall_o (cs_fall)
  );

  sar_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dclk_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i(dclk_i),
    .lvl_o  (dclk_lvl),
    .fall_o (dclk_fall)
  );

  sar_frame_seq #(.DATA_W(DATA_W), .ACQ_FALLS(ACQ_FALLS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cs_lvl   (cs_lvl),
    .cs_fall  (cs_fall),
    .dclk_fall(dclk_fall & ~dclk_lvl),
    .sample_i (sample_i),
    .phase_o  (phase),
    .idx_o    (idx),
    .dout_o   (dout_o),
    .oe_o     (dout_oe_o)
  );

  sar_status u_status (
    .phase_i(phase),
    .pwr_o  (pwr_state_o),
    .done_o (cycle_done_o)
  );

  assign bit_pos_o = idx;

endmodule

// File: rtl/sar_port_emu_chk.sv
module sar_port_emu_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_lvl,
  input logic             cs_fall,
  input logic             dclk_fall,
  input logic             dout,
  input logic             dout_oe,
  input logic [1:0]       pwr,
  input logic [IDX_W-1:0] bit_pos,
  input logic             cycle_done
);

  // R1
  cs_high_release_chk: assert property (@(posedge clk) disable iff (rst)
    cs_lvl |=> (!dout_oe && pwr == 2'b10 && !cycle_done));

  // R2
  frame_start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (!dout_oe && pwr == 2'b00));

  // R3
  lead_in_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_oe) |-> (!dout && $past(dclk_fall)));

  // R6
  done_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (cycle_done && !cs_lvl) |=> (cycle_done && !dout_oe));

  // R7
  pwr_code_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pwr));

  // R9
  no_change_between_falls_chk: assert property (@(posedge clk) disable iff (rst)
    (!dclk_fall && !cs_fall && !cs_lvl) |=>
      ($stable(dout) && $stable(dout_oe) && $stable(bit_pos)));

endmodule

bind sar_port_emu sar_port_emu_chk #(.IDX_W($clog2(DATA_W))) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_lvl    (cs_lvl),
  .cs_fall   (cs_fall),
  .dclk_fall (dclk_fall),
  .dout      (dout_o),
  .dout_oe   (dout_oe_o),
  .pwr       (pwr_state_o),
  .bit_pos   (bit_pos_o),
  .cycle_done(cycle_done_o)
);

// File: tb/sar_port_emu_test.sv
`timescale 1ns/1ps
module sar_port_emu_test;

  localparam int DW   = 16;
  localparam int HALF = 4;
  localparam int NVEC = 6;
  // each entry: sample word [23:8], data-clock falls before chip select rises [7:0]
  localparam logic [23:0] VECS [0:NVEC-1] = '{
    24'hA5C3_28,  // full frame plus ignored falls
    24'h7FFF_24,  // stop right after replayed B15
    24'h8000_15,  // stop right after forward B0
    24'h0001_0A,  // abort inside forward word
    24'hFFFF_03,  // abort inside acquisition
    24'h1234_25   // stop on the release fall
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          dclk = 1'b0;
  logic [DW-1:0] sample = '0;
  logic          dout;
  logic          dout_oe;
  logic [1:0]    pwr;
  logic [3:0]    bit_pos;
  logic          done;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  sar_port_emu uut (
    .clk         (clk),
    .rst         (rst),
    .cs_n_i      (cs_n),
    .dclk_i      (dclk),
    .sample_i    (sample),
    .dout_o      (dout),
    .dout_oe_o   (dout_oe),
    .pwr_state_o (pwr),
    .bit_pos_o   (bit_pos),
    .cycle_done_o(done)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit e_oe(input int k);
    return (k >= 5 && k <= 36);
  endfunction

  function automatic bit e_dout(input logic [DW-1:0] w, input int k);
    if (k <= 5 || k >= 37) return 1'b0;
    if (k <= 21) return w[21-k];
    return w[k-21];
  endfunction

  function automatic int e_pos(input int k);
    if (k >= 6 && k <= 21) return 21 - k;
    if (k >= 22 && k <= 36) return k - 21;
    return 0;
  endfunction

  function automatic string phase_tag(input int k);
    if (k == 0)  return "R2";
    if (k <= 5)  return "R3";
    if (k <= 21) return "R4";
    if (k <= 36) return "R5";
    return "R6";
  endfunction

  task automatic expect_at(input logic [DW-1:0] w, input int k);
    string t;
    t = phase_tag(k);
    chk({t, " oe"}, int'(dout_oe), int'(e_oe(k)));
    if (e_oe(k)) chk({t, " dout"}, int'(dout), int'(e_dout(w, k)));
    chk({t, " bit_pos"}, int'(bit_pos), e_pos(k));
    chk({t, " done"}, int'(done), (k >= 37) ? 1 : 0);
    chk("R7 pwr", int'(pwr), (k >= 22) ? 1 : 0);
  endtask

  task automatic run_frame(input logic [DW-1:0] w, input int n);
    sample = w;
    dclk   = 1'b0;
    tick(2);
    cs_n = 1'b0;
    tick(HALF);
    sample = ~w;  // R2: late change must not reach the line
    expect_at(w, 0);
    for (int k = 1; k <= n; k++) begin
      dclk = 1'b1;
      tick(HALF);
      // R9: rising edge leaves the line as it was
      chk("R9 oe", int'(dout_oe), int'(e_oe(k-1)));
      if (e_oe(k-1)) chk("R9 dout", int'(dout), int'(e_dout(w, k-1)));
      dclk = 1'b0;
      tick(HALF);
      expect_at(w, k);
    end
    cs_n = 1'b1;
    tick(HALF);
    chk("R8 oe", int'(dout_oe), 0);
    chk("R8 pwr", int'(pwr), 2);
    chk("R8 done", int'(done), 0);
    chk("R8 bit_pos", int'(bit_pos), 0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(2);
    // R10: reset state
    chk("R10 oe", int'(dout_oe), 0);
    chk("R10 pwr", int'(pwr), 2);
    chk("R10 done", int'(done), 0);
    chk("R10 bit_pos", int'(bit_pos), 0);

    // R1: data clock toggling with chip select high
    for (int i = 0; i < 8; i++) begin
      dclk = ~dclk;
      tick(HALF);
      chk("R1 oe", int'(dout_oe), 0);
      chk("R1 pwr", int'(pwr), 2);
    end
    dclk = 1'b0;
    tick(HALF);

    // table of frames
    for (int v = 0; v < NVEC; v++) begin
      run_frame(VECS[v][23:8], int'(VECS[v][7:0]));
      tick(HALF);
    end

    // R6: a fresh frame after a finished one starts cleanly
    run_frame(16'h5A5A, 23);

    // R10: reset in mid-word returns to idle
    sample = 16'hC0DE;
    cs_n   = 1'b0;
    tick(HALF);
    for (int k = 1; k <= 8; k++) begin
      dclk = 1'b1; tick(HALF);
      dclk = 1'b0; tick(HALF);
    end
    chk("R10 pre oe", int'(dout_oe), 1);
    rst = 1'b1;
    tick(2);
    rst  = 1'b0;
    cs_n = 1'b1;
    tick(1);
    chk("R10 mid oe", int'(dout_oe), 0);
    chk("R10 mid pwr", int'(pwr), 2);
    chk("R10 mid bit_pos", int'(bit_pos), 0);
    tick(HALF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule